// File: doc/BRIEF.md
# MSI-X Vector Table Controller

The block keeps a message-signalled interrupt vector table and a pending-bit array for `NVEC` vectors. Each vector entry stores a 64-bit message address, a 32-bit message data word and a per-vector mask bit. Software reads and writes both regions through a 32-bit register bus, and it changes the enable and function-mask flags through a separate byte-wide control port.

A device asks for an interrupt on a vector through the notify port. If the vector is live and unmasked, the block emits the entry's address and data on a valid/ready message port. If the vector is masked, the block records a pending bit instead. When a masked vector later becomes unmasked, its pending interrupt is replayed. A walk over the vectors in ascending order does this replay. A control write that changes the function mask starts the walk, and so does a table write that unmasks a vector with a pending bit. Per-vector use counts decide which vectors are live.

The controller is a four-state machine. The states are `ST_IDLE`, `ST_SEND`, `ST_SCAN` and `ST_SCAN_SEND`, with these transitions:
- `ST_IDLE` goes to `ST_SCAN` when a walk is requested. It goes to `ST_SEND` when it accepts a live, unmasked notify.
- `ST_SEND` returns to `ST_IDLE` on a message handshake.
- `ST_SCAN` goes to `ST_SCAN_SEND` when the current vector is due. It goes to `ST_IDLE` after the last vector. Otherwise it steps to the next vector.
- `ST_SCAN_SEND` goes back to `ST_SCAN` on a handshake. After the last vector it goes to `ST_IDLE` instead.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset, every table word reads zero except each vector-control word, which reads 1 (masked). All pending bits are zero, enable and function-mask are clear, no message is valid, and the notify port is ready.
- R2: Vector v occupies table bytes 16v..16v+15. The words are: address low at +0, address high at +4, data at +8, and a control word at +12 whose bit 0 is the mask; the control word's other bits read 0. A misaligned table address, or one at or beyond 16·NVEC, reads 0, and writes to it are ignored.
- R3: Pending word k bit j holds vector 32k+j. The pending region spans ceil(NVEC/64)·8 bytes, and reads beyond it return 0. Writes to the pending region have no effect.
- R4: The control byte carries enable in bit 7 and function-mask in bit 6; its other bits are ignored. `ctl_word` reads {enable, function-mask, 3'b000, NVEC-1}, and the size field cannot be written.
- R5: `intx_deassert` pulses high for one cycle, on the cycle after a control write with enable set, and at no other time.
- R6: A notify is consumed without effect when the vector index is NVEC or more, or when the vector's use count is zero.
- R7: A notify to a live vector that is masked sets its pending bit and emits nothing. A vector counts as masked when enable is clear, function-mask is set, or its own mask bit is set.
- R8: A notify to a live, unmasked vector raises `msg_valid` with that entry's address and data. The message stays stable until `msg_ready`, `msg_valid` drops after the handshake, and `ntf_ready` is low while a message is outstanding.
- R9: A table write that unmasks a vector whose pending bit is set clears that bit and emits that vector's message.
- R10: A control write that leaves the function enabled with a changed function mask walks all vectors in ascending order. Each live vector that is pending and now unmasked is cleared and emitted in index order. Vectors still masked keep their pending bits.
- R11: A use increments a vector's count. An unuse decrements a nonzero count, and when the count reaches zero it clears the pending bit. Use and unuse with an index of NVEC or more are ignored.
- R12: No message starts unless, in the cycle before it appears, enable is set and function-mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Region select: 0 table, 1 pending array |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_addr | input | BUS_AW | Byte address inside the selected region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_sel/bus_addr |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_byte | input | 8 | High byte of the message control word |
| ctl_word | output | 16 | Message control word read view |
| intx_deassert | output | 1 | One-cycle legacy interrupt deassert pulse |
| ntf_valid | input | 1 | Interrupt request valid |
| ntf_vec | input | IDX_W | Requested vector index |
| ntf_ready | output | 1 | Notify request accepted this cycle |
| use_valid | input | 1 | Use-count operation strobe |
| use_inc | input | 1 | 1 = use, 0 = unuse |
| use_vec | input | IDX_W | Vector for the use-count operation |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench checks that a vector is replayed on any masked-to-unmasked change. A design that judged masking on the per-vector bit alone would emit while the function is masked. A design that forgot the replay would leave the bit set and never send. The bench also checks the ascending order of a function-wide walk and that vectors still individually masked stay pending through that walk; an off-by-one scan counter would skip the first or last vector. It also covers notifies to unused and out-of-range vectors, whose counts and pending bits must not change. Unuse down to zero must clear a pending bit, while an unuse that leaves the count nonzero must keep the vector live. Finally the bench writes the pending array and low control bits, which must not change the pending bits or the enable and mask flags. It holds back `msg_ready` to confirm that the message holds stable and that notifies stall while it is outstanding.

// File: rtl/msix_pkg.sv
package msix_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SEND      = 2'd1,
        ST_SCAN      = 2'd2,
        ST_SCAN_SEND = 2'd3
    } fsm_state_t;

    localparam int unsigned ENTRY_BYTES = 16;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table #(
    parameter int NVEC   = 8,
    parameter int BUS_AW = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              fmask,
    output logic [31:0]       rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [63:0]       lk_addr,
    output logic [31:0]       lk_data,
    output logic              lk_vmask,
    output logic              wr_unmask,
    output logic [IDX_W-1:0]  wr_vec
);
    localparam int EW        = (NVEC > 1) ? $clog2(NVEC) : 1;
    localparam int TBL_BYTES = NVEC * msix_pkg::ENTRY_BYTES;

    logic [31:0]     a_lo [NVEC];
    logic [31:0]     a_hi [NVEC];
    logic [31:0]     dat  [NVEC];
    logic [NVEC-1:0] msk;

    logic          hit;
    logic [EW-1:0] ent_s;
    logic [1:0]    word;
    logic          lk_ok;
    logic [EW-1:0] lk_s;

    assign ent_s = addr[EW+3:4];
    assign word  = addr[3:2];
    assign hit   = (addr[1:0] == 2'b00) && (addr < BUS_AW'(TBL_BYTES));

    always_comb begin
        rd_data = '0;
        if (hit) begin
            case (word)
                2'd0:    rd_data = a_lo[ent_s];
                2'd1:    rd_data = a_hi[ent_s];
                2'd2:    rd_data = dat[ent_s];
                default: rd_data = {31'b0, msk[ent_s]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NVEC; i++) begin
                a_lo[i] <= '0;
                a_hi[i] <= '0;
                dat[i]  <= '0;
            end
            msk <= '1;
        end else if (wr_en && hit) begin
            case (word)
                2'd0:    a_lo[ent_s] <= wdata;
                2'd1:    a_hi[ent_s] <= wdata;
                2'd2:    dat[ent_s]  <= wdata;
                default: msk[ent_s]  <= wdata[0];
            endcase
        end
    end

    // Masked before the write, unmasked after it.
    assign wr_unmask = wr_en && hit && (word == 2'd3) && !fmask
                       && msk[ent_s] && !wdata[0];
    assign wr_vec    = IDX_W'(ent_s);

    assign lk_ok    = lk_idx < IDX_W'(NVEC);
    assign lk_s     = lk_idx[EW-1:0];
    assign lk_addr  = lk_ok ? {a_hi[lk_s], a_lo[lk_s]} : 64'd0;
    assign lk_data  = lk_ok ? dat[lk_s] : 32'd0;
    assign lk_vmask = lk_ok ? msk[lk_s] : 1'b1;
endmodule

// File: rtl/msix_pend_use.sv
module msix_pend_use #(
    parameter int NVEC   = 8,
    parameter int BUS_AW = 16,
    parameter int IDX_W  = 4,
    parameter int USE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              use_valid,
    input  logic              use_inc,
    input  logic [IDX_W-1:0]  use_vec,
    input  logic [BUS_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [NVEC-1:0]   pend,
    output logic [NVEC-1:0]   used
);
    localparam int PBA_BYTES = ((NVEC + 63) / 64) * 8;
    localparam int PBA_BITS  = PBA_BYTES * 8;
    localparam int WW        = $clog2(PBA_BYTES / 4);

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        logic [USE_W-1:0] cnt_q;
        logic             pend_q;
        logic             hit_use;
        logic             to_zero;

        assign hit_use = use_valid && (use_vec == IDX_W'(g));
        assign to_zero = hit_use && !use_inc && (cnt_q == USE_W'(1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit_use) begin
                if (use_inc && (cnt_q != '1))
                    cnt_q <= cnt_q + USE_W'(1);
                else if (!use_inc && (cnt_q != '0))
                    cnt_q <= cnt_q - USE_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q <= 1'b0;
            else if ((clr_en && (clr_idx == IDX_W'(g))) || to_zero)
                pend_q <= 1'b0;
            else if (set_en && (set_idx == IDX_W'(g)))
                pend_q <= 1'b1;
        end

        assign pend[g] = pend_q;
        assign used[g] = (cnt_q != '0);
    end

    logic [PBA_BITS-1:0] pad;
    logic [WW-1:0]       wsel;
    logic                hit;

    always_comb begin
        pad            = '0;
        pad[NVEC-1:0]  = pend;
    end

    assign wsel    = rd_addr[WW+1:2];
    assign hit     = (rd_addr[1:0] == 2'b00) && (rd_addr < BUS_AW'(PBA_BYTES));
    assign rd_data = hit ? pad[wsel*32 +: 32] : 32'd0;
endmodule

// File: rtl/msix_ctl_fsm.sv
module msix_ctl_fsm #(
    parameter int NVEC  = 8,
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ntf_valid,
    input  logic                 ntf_ok,
    input  logic                 ntf_masked,
    input  logic                 scan_trig,
    input  logic                 scan_due,
    input  logic                 msg_ready,
    output msix_pkg::fsm_state_t state,
    output logic [IDX_W-1:0]     scan_idx,
    output logic                 ntf_ready,
    output logic                 load_msg,
    output logic                 set_pend,
    output logic                 clr_pend,
    output logic                 msg_valid
);
    import msix_pkg::*;

    fsm_state_t state_d;
    logic       scan_req;
    logic       last;
    logic       start;
    logic       take;

    assign last  = (scan_idx == IDX_W'(NVEC - 1));
    assign start = (state == ST_IDLE) && scan_req;
    assign take  = (state == ST_IDLE) && !scan_req && ntf_valid && ntf_ok;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:      if (scan_req)               state_d = ST_SCAN;
                          else if (take && !ntf_masked) state_d = ST_SEND;
            ST_SEND:      if (msg_ready)              state_d = ST_IDLE;
            ST_SCAN:      if (scan_due)               state_d = ST_SCAN_SEND;
                          else if (last)              state_d = ST_IDLE;
            ST_SCAN_SEND: if (msg_ready)              state_d = last ? ST_IDLE : ST_SCAN;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            scan_req <= 1'b0;
        end else begin
            state    <= state_d;
            scan_req <= (scan_req && !start) || scan_trig;
            if (start)
                scan_idx <= '0;
            else if (((state == ST_SCAN) && !scan_due && !last) ||
                     ((state == ST_SCAN_SEND) && msg_ready && !last))
                scan_idx <= scan_idx + IDX_W'(1);
        end
    end

    always_comb begin
        ntf_ready = 1'b0;
        load_msg  = 1'b0;
        set_pend  = 1'b0;
        clr_pend  = 1'b0;
        msg_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ntf_ready = !scan_req;
                load_msg  = take && !ntf_masked;
                set_pend  = take && ntf_masked;
            end
            ST_SEND:      msg_valid = 1'b1;
            ST_SCAN: begin
                load_msg = scan_due;
                clr_pend = scan_due;
            end
            ST_SCAN_SEND: msg_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl #(
    parameter int NVEC   = 8,
    parameter int BUS_AW = 16,
    parameter int USE_W  = 4,
    parameter int IDX_W  = $clog2(NVEC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_byte,
    output logic [15:0]       ctl_word,
    output logic              intx_deassert,
    input  logic              ntf_valid,
    input  logic [IDX_W-1:0]  ntf_vec,
    output logic              ntf_ready,
    input  logic              use_valid,
    input  logic              use_inc,
    input  logic [IDX_W-1:0]  use_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);
    import msix_pkg::*;

    logic en_q, fm_q, intx_q, fmask;
    logic [31:0] tbl_rd, pba_rd;
    logic [63:0] lk_addr;
    logic [31:0] lk_data;
    logic        lk_vmask, lk_pend, lk_used, lk_in;
    logic        wr_unmask, wr_pend, scan_trig, scan_due;
    logic [IDX_W-1:0] wr_vec, scan_idx, lk_idx;
    logic [NVEC-1:0]  pend, used;
    logic        load_msg, set_pend, clr_pend;
    fsm_state_t  state;

    assign fmask = !en_q || fm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fm_q   <= 1'b0;
            intx_q <= 1'b0;
        end else begin
            intx_q <= ctl_wr && ctl_byte[7];
            if (ctl_wr) begin
                en_q <= ctl_byte[7];
                fm_q <= ctl_byte[6];
            end
        end
    end

    assign intx_deassert = intx_q;
    assign ctl_word      = {en_q, fm_q, 3'b000, 11'(NVEC - 1)};

    assign lk_idx   = (state == ST_SCAN) ? scan_idx : ntf_vec;
    assign lk_in    = lk_idx < IDX_W'(NVEC);
    assign lk_pend  = |(pend & (NVEC'(1) << lk_idx));
    assign lk_used  = |(used & (NVEC'(1) << lk_idx));
    assign wr_pend  = |(pend & (NVEC'(1) << wr_vec));
    assign scan_due = lk_pend && lk_used && !fmask && !lk_vmask;

    assign scan_trig = (ctl_wr && ctl_byte[7] && (ctl_byte[6] != fmask))
                       || (wr_unmask && wr_pend);

    msix_vec_table #(.NVEC(NVEC), .BUS_AW(BUS_AW), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && !bus_sel), .addr(bus_addr), .wdata(bus_wdata),
        .fmask(fmask), .rd_data(tbl_rd),
        .lk_idx(lk_idx), .lk_addr(lk_addr), .lk_data(lk_data), .lk_vmask(lk_vmask),
        .wr_unmask(wr_unmask), .wr_vec(wr_vec)
    );

    msix_pend_use #(.NVEC(NVEC), .BUS_AW(BUS_AW), .IDX_W(IDX_W), .USE_W(USE_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_pend), .set_idx(ntf_vec),
        .clr_en(clr_pend), .clr_idx(scan_idx),
        .use_valid(use_valid), .use_inc(use_inc), .use_vec(use_vec),
        .rd_addr(bus_addr), .rd_data(pba_rd),
        .pend(pend), .used(used)
    );

    msix_ctl_fsm #(.NVEC(NVEC), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ntf_valid(ntf_valid), .ntf_ok(lk_in && lk_used),
        .ntf_masked(fmask || lk_vmask),
        .scan_trig(scan_trig), .scan_due(scan_due), .msg_ready(msg_ready),
        .state(state), .scan_idx(scan_idx), .ntf_ready(ntf_ready),
        .load_msg(load_msg), .set_pend(set_pend), .clr_pend(clr_pend),
        .msg_valid(msg_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (load_msg) begin
            msg_addr <= lk_addr;
            msg_data <= lk_data;
        end
    end

    assign bus_rdata = bus_sel ? pba_rd : tbl_rd;
endmodule

// File: rtl/msix_vector_ctrl_chk.sv
module msix_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        ntf_ready,
    input logic        ctl_wr,
    input logic [7:0]  ctl_byte,
    input logic [15:0] ctl_word,
    input logic        intx_deassert
);
    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    assert_msg_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !ntf_ready);

    assert_intx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        intx_deassert |-> $past(ctl_wr && ctl_byte[7]));

    assert_emit_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(ctl_word[15] && !ctl_word[14]));
endmodule

bind msix_vector_ctrl msix_vector_ctrl_chk u_chk (.*);

// File: tb/tb_msix_vector_ctrl.sv
module tb_msix_vector_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int BUS_AW = 16;
    localparam int IDX_W = $clog2(NVEC) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic ctl_wr = 1'b0;
    logic [7:0] ctl_byte = '0;
    logic [15:0] ctl_word;
    logic intx_deassert;
    logic ntf_valid = 1'b0;
    logic [IDX_W-1:0] ntf_vec = '0;
    logic ntf_ready;
    logic use_valid = 1'b0, use_inc = 1'b0;
    logic [IDX_W-1:0] use_vec = '0;
    logic msg_valid, msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msix_vector_ctrl #(.NVEC(NVEC), .BUS_AW(BUS_AW)) dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pba_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic s, input logic [BUS_AW-1:0] a, output logic [31:0] v);
        bus_sel = s; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ctl_write(input logic [7:0] b);
        ctl_byte = b; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic use_op(input int v, input logic inc);
        use_vec = IDX_W'(v); use_inc = inc; use_valid = 1'b1;
        @(negedge clk);
        use_valid = 1'b0;
    endtask

    task automatic notify(input int v);
        int guard = 0;
        ntf_vec = IDX_W'(v); ntf_valid = 1'b1;
        while (!ntf_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        ntf_valid = 1'b0;
    endtask

    task automatic wait_msg(input string tag, input logic [63:0] ea, input logic [31:0] ed,
                            input bit stall);
        int guard = 0;
        while (!msg_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " valid"}, 64'(msg_valid), 64'd1);
        check({tag, " addr"}, msg_addr, ea);
        check({tag, " data"}, 64'(msg_data), 64'(ed));
        if (stall) begin
            repeat (3) @(negedge clk);
            check({tag, " hold valid"}, 64'(msg_valid), 64'd1);
            check({tag, " hold addr"}, msg_addr, ea);
            check({tag, " stall ntf_ready"}, 64'(ntf_ready), 64'd0);
        end
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        check({tag, " release"}, 64'(msg_valid), 64'd0);
    endtask

    task automatic no_msg(input string tag, input int n);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(tag, 64'(seen), 64'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 ctl_word", 64'(ctl_word), 64'h0007);
        rd(1'b0, 16'h000C, v); check("R1 vec0 mask", 64'(v), 64'd1);
        rd(1'b0, 16'h007C, v); check("R1 vec7 mask", 64'(v), 64'd1);
        rd(1'b0, 16'h0000, v); check("R1 vec0 addr", 64'(v), 64'd0);
        rd(1'b1, 16'h0000, v); check("R1 pending", 64'(v), 64'd0);
        check("R1 msg_valid", 64'(msg_valid), 64'd0);
        check("R1 ntf_ready", 64'(ntf_ready), 64'd1);
    endtask

    task automatic t_table;
        logic [31:0] v;
        tbl_write(16'h0020, 32'hFEE0_1000);
        tbl_write(16'h0024, 32'h0000_0001);
        tbl_write(16'h0028, 32'h0000_0042);
        rd(1'b0, 16'h0020, v); check("R2 addr lo", 64'(v), 64'hFEE0_1000);
        rd(1'b0, 16'h0024, v); check("R2 addr hi", 64'(v), 64'h1);
        rd(1'b0, 16'h0028, v); check("R2 data", 64'(v), 64'h42);
        rd(1'b0, 16'h0021, v); check("R2 misaligned", 64'(v), 64'd0);
        tbl_write(16'h0080, 32'h0000_FFFF);
        rd(1'b0, 16'h0080, v); check("R2 beyond table", 64'(v), 64'd0);
        tbl_write(16'h0022, 32'h1234_5678);
        rd(1'b0, 16'h0020, v); check("R2 misaligned write", 64'(v), 64'hFEE0_1000);
        tbl_write(16'h002C, 32'hFFFF_FFFE);
        rd(1'b0, 16'h002C, v); check("R2 ctrl bit0 only", 64'(v), 64'd0);
        tbl_write(16'h002C, 32'h0000_0001);
        no_msg("R12 no msg while disabled", 5);
    endtask

    task automatic t_ctl;
        ctl_write(8'h80);
        check("R5 intx pulse", 64'(intx_deassert), 64'd1);
        check("R4 enabled", 64'(ctl_word), 64'h8007);
        @(negedge clk);
        check("R5 intx one cycle", 64'(intx_deassert), 64'd0);
        ctl_write(8'hC0);
        check("R4 fmask", 64'(ctl_word), 64'hC007);
        ctl_write(8'h00);
        check("R5 no pulse when disabled", 64'(intx_deassert), 64'd0);
        check("R4 cleared", 64'(ctl_word), 64'h0007);
        ctl_write(8'h3F);
        check("R4 low bits ignored", 64'(ctl_word), 64'h0007);
        ctl_write(8'h80);
        no_msg("R10 empty walk silent", 20);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        tbl_write(16'h0030, 32'hFEE0_3000);
        tbl_write(16'h0038, 32'h0000_0033);
        tbl_write(16'h003C, 32'h0);
        notify(3);
        no_msg("R6 unused vector dropped", 10);
        rd(1'b1, 16'h0, v); check("R6 unused no pending", 64'(v), 64'd0);
        notify(9);
        no_msg("R6 out of range dropped", 10);
        use_op(9, 1'b1);
        notify(3);
        no_msg("R11 out of range use ignored", 10);
    endtask

    task automatic t_direct;
        use_op(3, 1'b1);
        notify(3);
        wait_msg("R8 direct", 64'hFEE0_3000, 32'h33, 1'b1);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        tbl_write(16'h003C, 32'h1);
        notify(3);
        no_msg("R7 masked no msg", 10);
        rd(1'b1, 16'h0, v); check("R7 pending set", 64'(v), 64'h8);
        pba_write(16'h0, 32'h0);
        rd(1'b1, 16'h0, v); check("R3 pending write ignored", 64'(v), 64'h8);
        rd(1'b1, 16'h8, v); check("R3 beyond pending", 64'(v), 64'd0);
        tbl_write(16'h003C, 32'h0);
        wait_msg("R9 replay", 64'hFEE0_3000, 32'h33, 1'b0);
        rd(1'b1, 16'h0, v); check("R9 pending cleared", 64'(v), 64'd0);
    endtask

    task automatic t_scan;
        logic [31:0] v;
        ctl_write(8'hC0);
        tbl_write(16'h0010, 32'hA1); tbl_write(16'h0018, 32'h11); tbl_write(16'h001C, 32'h0);
        tbl_write(16'h0050, 32'hA5); tbl_write(16'h0058, 32'h55); tbl_write(16'h005C, 32'h0);
        tbl_write(16'h0060, 32'hA6); tbl_write(16'h0068, 32'h66);
        use_op(1, 1'b1); use_op(5, 1'b1); use_op(6, 1'b1);
        notify(5); notify(1); notify(6);
        no_msg("R7 function masked", 10);
        rd(1'b1, 16'h0, v); check("R10 pending before", 64'(v), 64'h62);
        ctl_write(8'h80);
        wait_msg("R10 first vec1", 64'hA1, 32'h11, 1'b0);
        wait_msg("R10 second vec5", 64'hA5, 32'h55, 1'b0);
        no_msg("R10 vec6 stays", 20);
        rd(1'b1, 16'h0, v); check("R10 masked stays pending", 64'(v), 64'h40);
    endtask

    task automatic t_use;
        logic [31:0] v;
        use_op(6, 1'b0);
        rd(1'b1, 16'h0, v); check("R11 unuse clears", 64'(v), 64'd0);
        use_op(1, 1'b1);
        use_op(1, 1'b0);
        notify(1);
        wait_msg("R11 still used", 64'hA1, 32'h11, 1'b0);
        use_op(1, 1'b0);
        notify(1);
        no_msg("R11 count zero drops", 10);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        ctl_write(8'h00);
        notify(5);
        no_msg("R12 disabled no msg", 10);
        rd(1'b1, 16'h0, v); check("R12 disabled pending", 64'(v), 64'h20);
        ctl_write(8'h80);
        wait_msg("R10 enable replay", 64'hA5, 32'h55, 1'b0);
        rd(1'b1, 16'h0, v); check("R10 replay cleared", 64'(v), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_ctl();
        t_drop();
        t_direct();
        t_masked();
        t_scan();
        t_use();
        t_disabled();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule